// File: doc/BRIEF.md
# Display Partition Scan Address Generator

This block produces the video memory word address used for each scanline of a raster display whose screen is split into up to four stacked regions. Each region is described by a 32-bit record in an external parameter RAM. The record gives the region's start address and its height in scanlines. At the top of a frame the block loads region 0. It then follows the scanlines inside each character row and steps the address by a programmable pitch whenever a row is complete. When a region's scanlines are used up, it moves to the next region and reloads from that region's record. With this arrangement, software can scroll several screen areas on their own by rewriting only the start addresses.

The surrounding video logic sends a one-cycle strobe at frame start and a one-cycle strobe for each scanline advance. It also supplies the pitch, the row height and a character-mode bit. The block reads region records through a synchronous read port, one word for each region, and presents the address together with a valid flag. Line strobes that arrive while a record is being fetched are queued and applied once the fetch is done.

Top module: `scan_partition_gen`

## Requirements
- R1: After reset, `scan_addr` is 0 and `addr_valid` is 1, with region 0 active and 1023 lines remaining. The 1023rd line strobe after reset, with no frame start, starts a fetch of region 1.
- R2: A fetch takes two cycles. In the cycle after the triggering edge, `pram_rd_en` is 1 and `pram_raddr` holds the region index. In the cycle after that, `pram_rd_en` is 0. `addr_valid` is 0 in both cycles and returns to 1 with the new address after the second edge.
- R3: A region record word is decoded as follows. Start address bits [15:0] come from word bits [15:0]. Start address bits [17:16] come from word bits [17:16]. Line count bits [3:0] come from word bits [23:20]. Line count bits [9:4] come from word bits [29:24]. A line count of 0 means 1024 lines.
- R4: Each processed line increments a row-line counter. When the incremented value equals `row_height`, the counter clears and `scan_addr` grows by the effective pitch, modulo 2^18. With no processed line, `scan_addr` holds.
- R5: If the incremented row-line value reaches 32 (bit 5 set) without being equal to `row_height`, the counter clears and no pitch is added.
- R6: A `pitch` input of 0 is treated as 256 words.
- R7: Each processed line decrements the remaining count. On the line that takes it from 1 to 0, the region index advances, going 3 back to 0, and the new region is fetched.
- R8: When `char_mode` is 1, a loaded start address keeps only its low 13 bits. Bits [17:13] are zero.
- R9: Line strobes that arrive during a fetch are counted, up to 7, and are applied one per cycle after the fetch completes. No line is processed while `addr_valid` is 0.
- R10: A frame start clears the row-line counter, clears any queued lines and sets the region index to 0 before the fetch. This holds even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the top of a frame |
| line_adv | input | 1 | One-cycle strobe per scanline advance |
| pitch | input | 8 | Words added per character row (0 means 256) |
| row_height | input | 6 | Scanlines per character row |
| char_mode | input | 1 | Character mode: mask loaded start to 13 bits |
| pram_rd_en | output | 1 | Parameter RAM read enable |
| pram_raddr | output | 2 | Region index to read |
| pram_rdata | input | 32 | Region record, valid the cycle after the read |
| scan_addr | output | 18 | Current scanline word address |
| addr_valid | output | 1 | High when no region fetch is in progress |

## Verification
A line strobe seen at one edge changes `scan_addr` at that same edge, or starts a fetch there. A fetch, whether started by a frame start or by a region running out, drops `addr_valid` for exactly the next two cycles, and the new address appears after the second edge. Queued strobes then take one further cycle each. The bench drives inputs on falling edges and samples on falling edges. Every expected value is read at the falling edge that follows the rising edge on which the result becomes due. In particular, the bench reads the read-enable pulse and the busy flag one falling edge after the strobe, and reads the loaded address two falling edges after that.

// File: rtl/sp_pkg.sv
package sp_pkg;

    // Fixed record format widths
    localparam int SP_ADDR_W = 18;
    localparam int SP_CHAR_W = 13;
    localparam int SP_LCNT_W = 10;
    localparam int SP_CNT_W  = SP_LCNT_W + 1;
    localparam int SP_WORD_W = 32;

    typedef struct packed {
        logic [SP_ADDR_W-1:0] start;
        logic [SP_CNT_W-1:0]  lines;
    } part_rec_t;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_REQ  = 2'd1,
        LD_CAP  = 2'd2
    } ld_state_e;

    // Build a region record from its fields; zero count stands for the maximum
    function automatic part_rec_t sp_decode(
        input logic [15:0] addr_lo,
        input logic [1:0]  addr_hi,
        input logic [3:0]  cnt_lo,
        input logic [5:0]  cnt_hi,
        input logic        chr
    );
        part_rec_t r;
        logic [SP_LCNT_W-1:0] c;
        r.start = {addr_hi, addr_lo};
        if (chr)
            r.start = r.start & SP_ADDR_W'((1 << SP_CHAR_W) - 1);
        c = {cnt_hi, cnt_lo};
        r.lines = (c == '0) ? SP_CNT_W'(1 << SP_LCNT_W) : {1'b0, c};
        return r;
    endfunction

endpackage

// File: rtl/sp_part_loader.sv
module sp_part_loader
    import sp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic rd_en,
    output logic cap,
    output logic busy
);

    ld_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
        end else if (kick) begin
            state_q <= LD_REQ;
        end else begin
            unique case (state_q)
                LD_REQ:  state_q <= LD_CAP;
                LD_CAP:  state_q <= LD_IDLE;
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign rd_en = (state_q == LD_REQ);
    assign cap   = (state_q == LD_CAP);
    assign busy  = (state_q != LD_IDLE);

endmodule

// File: rtl/sp_row_track.sv
module sp_row_track #(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [ROW_W-1:0] row_height,
    output logic             wrap
);

    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_next;

    assign row_next = row_q + 1'b1;
    assign wrap     = step && (row_next == row_height);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            row_q <= '0;
        end else if (step) begin
            if (wrap || row_next[ROW_W-1])
                row_q <= '0;
            else
                row_q <= row_next;
        end
    end

endmodule

// File: rtl/sp_line_queue.sv
module sp_line_queue #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic busy,
    input  logic line_adv,
    output logic step
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] pend_q;

    assign step = !busy && !flush && (line_adv || (pend_q != '0));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= '0;
        end else if (line_adv && !step) begin
            if (pend_q != PEND_MAX)
                pend_q <= pend_q + 1'b1;
        end else if (!line_adv && step) begin
            pend_q <= pend_q - 1'b1;
        end
    end

endmodule

// File: rtl/scan_partition_gen.sv
module scan_partition_gen
    import sp_pkg::*;
#(
    parameter int PARTS   = 4,
    parameter int PITCH_W = 8,
    parameter int ROW_W   = 6,
    parameter int PEND_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_start,
    input  logic                          line_adv,
    input  logic [PITCH_W-1:0]            pitch,
    input  logic [ROW_W-1:0]              row_height,
    input  logic                          char_mode,
    output logic                          pram_rd_en,
    output logic [$clog2(PARTS)-1:0]      pram_raddr,
    input  logic [SP_WORD_W-1:0]          pram_rdata,
    output logic [SP_ADDR_W-1:0]          scan_addr,
    output logic                          addr_valid
);

    localparam int IDX_W = $clog2(PARTS);
    localparam logic [IDX_W-1:0]    IDX_LAST   = IDX_W'(PARTS - 1);
    localparam logic [SP_CNT_W-1:0] RESET_CNT  = SP_CNT_W'((1 << SP_LCNT_W) - 1);
    localparam logic [PITCH_W:0]    PITCH_FULL = (PITCH_W+1)'(1 << PITCH_W);

    logic               q_step;
    logic               ld_cap;
    logic               ld_busy;
    logic               row_wrap;
    logic               exhaust;
    logic               kick;
    logic [IDX_W-1:0]   idx_q;
    logic [SP_ADDR_W-1:0] addr_q;
    logic [SP_CNT_W-1:0]  remain_q;
    logic [PITCH_W:0]   pitch_eff;
    part_rec_t          rec;
    logic               unused_rsvd;

    assign unused_rsvd = ^{pram_rdata[31:30], pram_rdata[19:18]};

    assign rec = sp_decode(pram_rdata[15:0], pram_rdata[17:16],
                           pram_rdata[23:20], pram_rdata[29:24], char_mode);

    assign pitch_eff = (pitch == '0) ? PITCH_FULL : {1'b0, pitch};
    assign exhaust   = q_step && (remain_q == SP_CNT_W'(1));
    assign kick      = frame_start || exhaust;

    sp_line_queue #(.PEND_W(PEND_W)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .flush    (frame_start),
        .busy     (ld_busy),
        .line_adv (line_adv),
        .step     (q_step)
    );

    sp_row_track #(.ROW_W(ROW_W)) u_row (
        .clk        (clk),
        .rst        (rst),
        .clr        (frame_start),
        .step       (q_step),
        .row_height (row_height),
        .wrap       (row_wrap)
    );

    sp_part_loader u_load (
        .clk   (clk),
        .rst   (rst),
        .kick  (kick),
        .rd_en (pram_rd_en),
        .cap   (ld_cap),
        .busy  (ld_busy)
    );

    always_ff @(posedge clk) begin
        if (rst || frame_start)
            idx_q <= '0;
        else if (exhaust)
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= RESET_CNT;
        end else if (ld_cap) begin
            addr_q   <= rec.start;
            remain_q <= rec.lines;
        end else if (q_step) begin
            remain_q <= remain_q - 1'b1;
            if (row_wrap)
                addr_q <= addr_q + SP_ADDR_W'(pitch_eff);
        end
    end

    assign pram_raddr = idx_q;
    assign scan_addr  = addr_q;
    assign addr_valid = !ld_busy;

endmodule

// File: rtl/sp_checker.sv
module sp_checker
    import sp_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 char_mode,
    input  logic                 pram_rd_en,
    input  logic [IDX_W-1:0]     pram_raddr,
    input  logic [SP_ADDR_W-1:0] scan_addr,
    input  logic                 addr_valid,
    input  logic                 step,
    input  logic                 cap
);

    assert_busy_after_frame_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !addr_valid);

    assert_capture_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
        (pram_rd_en && !frame_start) |=> (!addr_valid && !pram_rd_en));

    assert_hold_without_line_R4: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !step) |=> $stable(scan_addr));

    assert_frame_reads_first_R10: assert property (@(posedge clk) disable iff (rst)
        (pram_rd_en && $past(frame_start)) |-> (pram_raddr == '0));

    assert_char_mask_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(cap) && addr_valid && char_mode && $past(char_mode))
            |-> ((scan_addr >> SP_CHAR_W) == '0));

    assert_no_line_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> !step);

endmodule

bind scan_partition_gen sp_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .char_mode   (char_mode),
    .pram_rd_en  (pram_rd_en),
    .pram_raddr  (pram_raddr),
    .scan_addr   (scan_addr),
    .addr_valid  (addr_valid),
    .step        (q_step),
    .cap         (ld_cap)
);

// File: tb/sim_scan_partition_gen.sv
module sim_scan_partition_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        line_adv = 1'b0;
    logic [7:0]  pitch = 8'd0;
    logic [5:0]  row_height = 6'd33;
    logic        char_mode = 1'b0;
    logic        pram_rd_en;
    logic [1:0]  pram_raddr;
    logic [31:0] pram_rdata = 32'd0;
    logic [17:0] scan_addr;
    logic        addr_valid;

    logic [31:0] mem [4];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_partition_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_adv    (line_adv),
        .pitch       (pitch),
        .row_height  (row_height),
        .char_mode   (char_mode),
        .pram_rd_en  (pram_rd_en),
        .pram_raddr  (pram_raddr),
        .pram_rdata  (pram_rdata),
        .scan_addr   (scan_addr),
        .addr_valid  (addr_valid)
    );

    // Synchronous-read parameter RAM model
    always @(posedge clk) begin
        if (pram_rd_en) pram_rdata <= mem[pram_raddr];
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Record encoding per R3
    task automatic set_part(input int i, input logic [17:0] st, input logic [9:0] n);
        mem[i] = {2'b00, n[9:4], n[3:0], 2'b00, st[17:16], st[15:8], st[7:0]};
    endtask

    task automatic pulse_frame;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic lines(input int n);
        line_adv = 1'b1;
        repeat (n) @(negedge clk);
        line_adv = 1'b0;
    endtask

    task automatic wait_load;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset_R1;
        chk("R1 reset addr", 32'(scan_addr), 32'h0);
        chk("R1 reset valid", 32'(addr_valid), 32'h1);
        set_part(1, 18'h00ABC, 10'd9);
        row_height = 6'd33;
        lines(1022);
        chk("R1 still valid at 1022", 32'(addr_valid), 32'h1);
        lines(1);
        chk("R1 fetch after 1023", 32'(addr_valid), 32'h0);
        chk("R1 fetch index", 32'(pram_raddr), 32'h1);
        @(negedge clk);
        @(negedge clk);
        chk("R1 region 1 loaded", 32'(scan_addr), 32'h00ABC);
    endtask

    task automatic test_load_R2_R3;
        set_part(0, 18'h21234, 10'd3);
        pulse_frame();
        chk("R2 busy cycle 1", 32'(addr_valid), 32'h0);
        chk("R2 read enable", 32'(pram_rd_en), 32'h1);
        chk("R2 read index", 32'(pram_raddr), 32'h0);
        @(negedge clk);
        chk("R2 busy cycle 2", 32'(addr_valid), 32'h0);
        chk("R2 read enable off", 32'(pram_rd_en), 32'h0);
        @(negedge clk);
        chk("R2 valid after load", 32'(addr_valid), 32'h1);
        chk("R3 start decode", 32'(scan_addr), 32'h21234);
    endtask

    task automatic test_row_R4_R7;
        row_height = 6'd2;
        pitch = 8'h50;
        set_part(1, 18'h00100, 10'd0);
        lines(1);
        chk("R4 mid row", 32'(scan_addr), 32'h21234);
        lines(1);
        chk("R4 row end adds pitch", 32'(scan_addr), 32'h21284);
        lines(1);
        chk("R7 region exhausted", 32'(addr_valid), 32'h0);
        chk("R7 next index", 32'(pram_raddr), 32'h1);
        wait_load();
        chk("R7 next region start", 32'(scan_addr), 32'h00100);
    endtask

    task automatic test_zero_count_R3;
        row_height = 6'd33;
        set_part(2, 18'h00777, 10'd5);
        lines(1023);
        chk("R3 zero count alive at 1023", 32'(addr_valid), 32'h1);
        lines(1);
        chk("R3 zero count ends at 1024", 32'(addr_valid), 32'h0);
        wait_load();
        chk("R3 region 2 loaded", 32'(scan_addr), 32'h00777);
    endtask

    task automatic test_pitch_zero_R6;
        set_part(0, 18'h00040, 10'h3FF);
        row_height = 6'd1;
        pitch = 8'd0;
        pulse_frame();
        wait_load();
        lines(1);
        chk("R6 zero pitch first", 32'(scan_addr), 32'h00140);
        lines(1);
        chk("R6 zero pitch second", 32'(scan_addr), 32'h00240);
        pitch = 8'd3;
        lines(1);
        chk("R4 small pitch", 32'(scan_addr), 32'h00243);
    endtask

    task automatic test_row32_R5;
        set_part(0, 18'h01000, 10'h3FF);
        row_height = 6'd33;
        pitch = 8'd8;
        pulse_frame();
        wait_load();
        lines(32);
        chk("R5 no pitch at 32", 32'(scan_addr), 32'h01000);
        row_height = 6'd2;
        lines(1);
        chk("R5 counter restarted", 32'(scan_addr), 32'h01000);
        lines(1);
        chk("R5 row after clear", 32'(scan_addr), 32'h01008);
    endtask

    task automatic test_char_R8;
        set_part(0, 18'h3FFFF, 10'h3FF);
        char_mode = 1'b1;
        pulse_frame();
        wait_load();
        chk("R8 char mask", 32'(scan_addr), 32'h01FFF);
        char_mode = 1'b0;
        pulse_frame();
        wait_load();
        chk("R8 graphics full", 32'(scan_addr), 32'h3FFFF);
    endtask

    task automatic test_wrap_R7_R10;
        logic [17:0] st [4];
        st[0] = 18'h00111; st[1] = 18'h00222; st[2] = 18'h00333; st[3] = 18'h00444;
        for (int i = 0; i < 4; i++) set_part(i, st[i], 10'd1);
        row_height = 6'd33;
        pulse_frame();
        wait_load();
        chk("R7 region 0", 32'(scan_addr), 32'(st[0]));
        for (int k = 1; k <= 4; k++) begin
            lines(1);
            wait_load();
            chk("R7 region sequence wraps", 32'(scan_addr), 32'(st[k % 4]));
        end
        lines(1);
        wait_load();
        lines(1);
        wait_load();
        chk("R10 at region 2", 32'(scan_addr), 32'(st[2]));
        pulse_frame();
        chk("R10 frame reads index 0", 32'(pram_raddr), 32'h0);
        wait_load();
        chk("R10 back to region 0", 32'(scan_addr), 32'(st[0]));
    endtask

    task automatic test_pending_R9;
        set_part(0, 18'h0A000, 10'd1);
        set_part(1, 18'h0B000, 10'd5);
        row_height = 6'd1;
        pitch = 8'd4;
        pulse_frame();
        wait_load();
        lines(3);
        @(negedge clk);
        @(negedge clk);
        chk("R9 queued lines applied", 32'(scan_addr), 32'h0B008);
        @(negedge clk);
        chk("R9 no extra line", 32'(scan_addr), 32'h0B008);
    endtask

    task automatic test_frame_row_R10;
        set_part(0, 18'h00000, 10'h3FF);
        row_height = 6'd3;
        pitch = 8'h10;
        pulse_frame();
        wait_load();
        lines(2);
        pulse_frame();
        wait_load();
        lines(2);
        chk("R10 row cleared at frame", 32'(scan_addr), 32'h0);
        lines(1);
        chk("R10 row end after frame", 32'(scan_addr), 32'h10);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_R1();
        test_load_R2_R3();
        test_row_R4_R7();
        test_zero_count_R3();
        test_pitch_zero_R6();
        test_row32_R5();
        test_char_R8();
        test_wrap_R7_R10();
        test_pending_R9();
        test_frame_row_R10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule